// File: doc/BRIEF.md
# Self-Starting Five-Code Sequence Counter

This block is a synchronous three-bit state machine that walks a fixed loop of five codes that do not follow binary order. Its next-state equations are chosen so that none of the three codes outside the loop can trap the machine. Whichever unused code the state lands in, after a glitch or at power-up, the machine returns to the loop within two enabled clocks.

The counter advances once per clock while its enable is high and holds while the enable is low. A synchronous reset returns it to the loop's first code. It reports its raw code, a flag that is high while the code belongs to the loop, and a single-cycle pulse in the cycle whose step closes the loop. A load input can place any three-bit code into the state, so the recovery paths can be exercised directly.

Top module: `fsc_counter`

## Requirements
- R1: While `rst` is high, the rising clock edge sets `state_q` to 000. This applies whatever `load_en` and `cnt_en` are.
- R2: With `cnt_en` high and `load_en` low, each edge moves the state one step around the loop 000, 010, 011, 101, 110 and back to 000. The code is read with `state_q[2]` as C, `state_q[1]` as B and `state_q[0]` as A.
- R3: With `rst`, `load_en` and `cnt_en` all low, the state keeps its value across the edge.
- R4: An enabled step from an unused code goes as follows: 001 moves to 110, 100 moves to 010, and 111 moves to 100.
- R5: Starting from any unused code, `in_loop` is high after at most two enabled steps.
- R6: `in_loop` is high exactly when `state_q` is 000, 010, 011, 101 or 110. It follows the state with no clock delay.
- R7: `wrap_pulse` is high exactly when `state_q` is 110, `cnt_en` is high and `load_en` is low. It is combinational, and the following edge yields 000.
- R8: With `rst` low and `load_en` high, the edge copies `load_code` into the state. The load takes priority over `cnt_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Advance the state one step per clock |
| load_en | input | 1 | Test hook: load `load_code` into the state |
| load_code | input | 3 | Code to load (C, B, A from MSB) |
| state_q | output | 3 | Current state code (C, B, A from MSB) |
| in_loop | output | 1 | Current code is one of the five loop codes |
| wrap_pulse | output | 1 | This step returns the loop to 000 |

## Verification
Two actions can fall on the same cycle. One is a wrap step from 110. The other is a load or a reset, and either one replaces that step. The bench drives state 110 with `cnt_en` high and raises `load_en` in the same cycle. It then checks that `wrap_pulse` stays low and that the loaded code, not 000, appears after the edge. It also asserts `rst` together with `load_en` and `cnt_en` and checks that 000 results. Random cycles mix all four controls, and a bench model that applies the same priority order judges each result.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int CODE_W = 3;
  typedef logic [CODE_W-1:0] code_t;

  // loop codes in visiting order
  localparam code_t LOOP_0 = 3'b000;
  localparam code_t LOOP_1 = 3'b010;
  localparam code_t LOOP_2 = 3'b011;
  localparam code_t LOOP_3 = 3'b101;
  localparam code_t LOOP_4 = 3'b110;

  // Next-state equations over bits C (msb), B, A (lsb).
  function automatic code_t next_code(input code_t cur);
    logic a, b, c;
    code_t nx;
    a = cur[0];
    b = cur[1];
    c = cur[2];
    nx[0] = b & ~c;
    nx[1] = ~b | (~a & ~c);
    nx[2] = a;
    return nx;
  endfunction

  function automatic logic is_loop_code(input code_t cur);
    return (cur == LOOP_0) || (cur == LOOP_1) || (cur == LOOP_2) ||
           (cur == LOOP_3) || (cur == LOOP_4);
  endfunction
endpackage

// File: rtl/fsc_next.sv
module fsc_next
  import fsc_pkg::*;
(
  input  code_t cur_code,
  output code_t nxt_code
);
  always_comb nxt_code = next_code(cur_code);
endmodule

// File: rtl/fsc_state_reg.sv
module fsc_state_reg
  import fsc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  step,
  input  logic  ld,
  input  code_t ld_code,
  input  code_t nxt,
  output code_t q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= LOOP_0;
    else if (ld)   q <= ld_code;
    else if (step) q <= nxt;
  end

  // R1
  reset_to_zero_chk: assert property (@(posedge clk) rst |=> q == LOOP_0);
  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld && !step) |=> $stable(q));
  // R8
  load_takes_code_chk: assert property (@(posedge clk) disable iff (rst)
    ld |=> q == $past(ld_code));
endmodule

// File: rtl/fsc_decode.sv
module fsc_decode
  import fsc_pkg::*;
(
  input  code_t q,
  input  logic  step,
  output logic  member,
  output logic  wrap
);
  always_comb begin
    member = is_loop_code(q);
    wrap   = step && (q == LOOP_4);
  end
endmodule

// File: rtl/fsc_counter.sv
module fsc_counter
  import fsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              load_en,
  input  logic [CODE_W-1:0] load_code,
  output logic [CODE_W-1:0] state_q,
  output logic              in_loop,
  output logic              wrap_pulse
);
  logic  step_go;
  code_t cur_code;
  code_t nxt_code;

  assign step_go = cnt_en & ~load_en;

  fsc_next u_next (
    .cur_code (cur_code),
    .nxt_code (nxt_code)
  );

  fsc_state_reg u_state (
    .clk     (clk),
    .rst     (rst),
    .step    (step_go),
    .ld      (load_en),
    .ld_code (load_code),
    .nxt     (nxt_code),
    .q       (cur_code)
  );

  fsc_decode u_decode (
    .q      (cur_code),
    .step   (step_go),
    .member (in_loop),
    .wrap   (wrap_pulse)
  );

  assign state_q = cur_code;

  // R2
  first_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step_go && cur_code == LOOP_0) |=> cur_code == LOOP_1);
  // R7
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_pulse |=> cur_code == LOOP_0);
  // R4
  worst_illegal_chk: assert property (@(posedge clk) disable iff (rst)
    (step_go && cur_code == 3'b111) |=> cur_code == 3'b100);
  // R5
  recovery_progress_chk: assert property (@(posedge clk) disable iff (rst)
    (step_go && !in_loop) |=> (in_loop || cur_code == 3'b100));
endmodule

// File: tb/fsc_counter_bench.sv
module fsc_counter_bench;
  logic       clk = 1'b0;
  logic       rst, cnt_en, load_en;
  logic [2:0] load_code;
  logic [2:0] state_q;
  logic       in_loop, wrap_pulse;

  int checks = 0;
  int errors = 0;
  logic [2:0] model;

  always #5 clk = ~clk;

  fsc_counter u_fsc_counter (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .load_en(load_en),
    .load_code(load_code), .state_q(state_q), .in_loop(in_loop),
    .wrap_pulse(wrap_pulse)
  );

  // loop order and recovery, written as a table
  function automatic logic [2:0] exp_next(input logic [2:0] c);
    case (c)
      3'b000: return 3'b010;
      3'b010: return 3'b011;
      3'b011: return 3'b101;
      3'b101: return 3'b110;
      3'b110: return 3'b000;
      3'b001: return 3'b110;
      3'b100: return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  function automatic logic exp_member(input logic [2:0] c);
    case (c)
      3'b001, 3'b100, 3'b111: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [2:0] exp_after(input logic [2:0] c, input logic r,
                                           input logic e, input logic l,
                                           input logic [2:0] lc);
    if (r) return 3'b000;
    if (l) return lc;
    if (e) return exp_next(c);
    return c;
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one cycle: check combinational outputs, clock, check state.
  task automatic cycle(input logic r, input logic e, input logic l,
                       input logic [2:0] lc, input string req);
    rst = r; cnt_en = e; load_en = l; load_code = lc;
    #1;
    check("R6", {3'b0, in_loop}, {3'b0, exp_member(model)});
    check("R7", {3'b0, wrap_pulse}, {3'b0, (e && !l && model == 3'b110)});
    model = exp_after(model, r, e, l, lc);
    @(posedge clk); #1;
    check(req, {1'b0, state_q}, {1'b0, model});
  endtask

  initial begin
    rst = 1'b1; cnt_en = 1'b0; load_en = 1'b0; load_code = 3'b000;
    model = 3'b000;
    void'($urandom(32'd2024));
    @(negedge clk);
    @(posedge clk); #1;
    check("R1", {1'b0, state_q}, 4'h0);
    @(negedge clk);
    // R2: full loop twice
    for (int i = 0; i < 10; i++) cycle(0, 1, 0, 3'b000, "R2");
    // R3: hold
    cycle(0, 1, 0, 3'b000, "R2");
    for (int i = 0; i < 3; i++) cycle(0, 0, 0, 3'b111, "R3");
    // R4 / R5: each unused code
    foreach (model[k]) begin end
    for (int i = 0; i < 3; i++) begin
      logic [2:0] bad;
      bad = (i == 0) ? 3'b001 : (i == 1) ? 3'b100 : 3'b111;
      cycle(0, 0, 1, bad, "R8");
      cycle(0, 1, 0, 3'b000, "R4");
      cycle(0, 1, 0, 3'b000, "R5");
      check("R5", {3'b0, in_loop}, 4'h1);
    end
    // R8: load collides with wrap step at 110
    cycle(0, 0, 1, 3'b110, "R8");
    cycle(0, 1, 1, 3'b011, "R8");
    // R1: reset overrides load and enable
    cycle(0, 0, 1, 3'b110, "R8");
    cycle(1, 1, 1, 3'b101, "R1");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic r, e, l;
      logic [2:0] c;
      string tag;
      r = ($urandom % 16) == 0;
      l = ($urandom % 6) == 0;
      e = ($urandom % 4) != 0;
      c = 3'($urandom);
      tag = r ? "R1" : l ? "R8" : !e ? "R3" : !exp_member(model) ? "R4" : "R2";
      cycle(r, e, l, c, tag);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule